// File: doc/BRIEF.md
# Circular Buffer Address Generator

This block generates indirect data addresses for a processor core. Each of its buffers keeps four registers: a pointer (index), a default step (modifier), a buffer length and a buffer start (base). A request names a buffer, picks pre-modify or post-modify addressing, and picks the step. The step is either the buffer's modifier register or a signed immediate value. A post-modify request issues the current pointer and writes back the advanced pointer. When the advanced pointer leaves the buffer, it is folded back inside by adding or subtracting the length. This gives delay lines and filter histories at any start address and any length, with no work by software.

There are two complete sets of buffer registers, a primary and a secondary one. A single bank bit chooses which set both the access path and the register port use. Software can therefore switch context in one write and leave the other set untouched. With the SIMD flag set, a request also produces the address of the neighbouring word, so that one access moves two data values.

Top module: `circ_agen`

## Requirements
- R1: During and after reset, the bank bit selects bank 0, every register of both banks reads zero, and out_valid_o is low.
- R2: A register write goes to the active bank, to the buffer given by reg_buf_i and the field given by reg_fld_i (0 index, 1 modifier, 2 length, 3 base). It takes effect at the next clock edge. reg_rdata_o shows the addressed field of the active bank combinationally.
- R3: A write to the base field also loads the same value into that buffer's index.
- R4: A post-modify request issues the current index. It then stores index+step, minus length when that sum is at or above base+length.
- R5: During a post-modify request, an index+step that falls below base is stored plus length.
- R6: A buffer with length zero does no wraparound. Its index advances linearly, modulo the address width.
- R7: A pre-modify request issues index+step without wraparound and leaves the index unchanged.
- R8: With acc_imm_i high, the step is the signed value on acc_step_i. Otherwise it is the buffer's modifier register, taken as signed.
- R9: out_pair_o is high exactly for SIMD requests, and out_addr2_o then equals out_addr_o+1.
- R10: A bank-select write changes the active bank from the next cycle on. The inactive bank keeps all its contents.
- R11: Each request produces out_valid_o and its addresses one cycle later. There is no output in a cycle without a request.
- R12: When a register write and a post-modify update hit the same index in the same cycle, the register write wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bank_we_i | input | 1 | Load the bank bit |
| bank_sel_i | input | 1 | New bank bit value |
| reg_we_i | input | 1 | Register write strobe |
| reg_buf_i | input | 4 | Buffer number for register access |
| reg_fld_i | input | 2 | Field: 0 index, 1 modifier, 2 length, 3 base |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, active bank |
| acc_valid_i | input | 1 | Address request |
| acc_buf_i | input | 4 | Buffer for the request |
| acc_pre_i | input | 1 | 1 pre-modify, 0 post-modify |
| acc_simd_i | input | 1 | Request a pair of addresses |
| acc_imm_i | input | 1 | Use acc_step_i in place of the modifier |
| acc_step_i | input | 32 | Signed immediate step |
| out_valid_o | output | 1 | Issued address valid |
| out_addr_o | output | 32 | Issued address |
| out_addr2_o | output | 32 | Second address of a SIMD pair |
| out_pair_o | output | 1 | Second address valid |

## Verification
Four things are checked by assertions on every cycle. First, each request produces exactly one registered result, and idle cycles produce none. Second, a post-modify issues the pointer as it was, and a pre-modify never writes the pointer back. Third, a SIMD pair is always adjacent, and the bank bit moves only on a select write. Fourth, a pointer that starts inside its buffer, with a step no larger than the length, lands inside the buffer again. Other behaviour shows only in the bench's scenarios against its own model: the exact wrapped values in both directions, the linear mode at length zero, the base-loads-index side effect, the contents of the inactive bank across a switch, and the write-over-update priority.

// File: rtl/circ_agen_pkg.sv
package circ_agen_pkg;
  typedef enum logic [1:0] {
    FLD_INDEX  = 2'd0,
    FLD_MODIFY = 2'd1,
    FLD_LENGTH = 2'd2,
    FLD_BASE   = 2'd3
  } fld_e;
endpackage

// File: rtl/circ_regbank.sv
module circ_regbank
  import circ_agen_pkg::*;
#(
  parameter int AW   = 32,
  parameter int NBUF = 16,
  localparam int BW  = $clog2(NBUF)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          bank_i,
  input  logic          we_i,
  input  logic [BW-1:0] wbuf_i,
  input  fld_e          wfld_i,
  input  logic [AW-1:0] wdata_i,
  input  logic          upd_i,
  input  logic [BW-1:0] ubuf_i,
  input  logic [AW-1:0] udata_i,
  input  logic [BW-1:0] abuf_i,
  output logic [AW-1:0] idx_o,
  output logic [AW-1:0] mod_o,
  output logic [AW-1:0] len_o,
  output logic [AW-1:0] base_o,
  input  logic [BW-1:0] rbuf_i,
  input  fld_e          rfld_i,
  output logic [AW-1:0] rdata_o
);
  localparam int NBANK = 2;

  logic [AW-1:0] idx_a  [NBANK];
  logic [AW-1:0] mod_a  [NBANK];
  logic [AW-1:0] len_a  [NBANK];
  logic [AW-1:0] base_a [NBANK];
  logic [AW-1:0] rd_a   [NBANK];

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    logic [AW-1:0] idx_q  [NBUF];
    logic [AW-1:0] mod_q  [NBUF];
    logic [AW-1:0] len_q  [NBUF];
    logic [AW-1:0] base_q [NBUF];
    logic          sel;

    assign sel = (bank_i == g[0]);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int n = 0; n < NBUF; n++) begin
          idx_q[n]  <= '0;
          mod_q[n]  <= '0;
          len_q[n]  <= '0;
          base_q[n] <= '0;
        end
      end else if (sel) begin
        if (upd_i) idx_q[ubuf_i] <= udata_i;
        // register write placed last: wins over pointer update
        if (we_i) begin
          case (wfld_i)
            FLD_INDEX:  idx_q[wbuf_i] <= wdata_i;
            FLD_MODIFY: mod_q[wbuf_i] <= wdata_i;
            FLD_LENGTH: len_q[wbuf_i] <= wdata_i;
            FLD_BASE: begin
              base_q[wbuf_i] <= wdata_i;
              idx_q[wbuf_i]  <= wdata_i;
            end
            default: ;
          endcase
        end
      end
    end

    assign idx_a[g]  = idx_q[abuf_i];
    assign mod_a[g]  = mod_q[abuf_i];
    assign len_a[g]  = len_q[abuf_i];
    assign base_a[g] = base_q[abuf_i];

    always_comb begin
      case (rfld_i)
        FLD_INDEX:  rd_a[g] = idx_q[rbuf_i];
        FLD_MODIFY: rd_a[g] = mod_q[rbuf_i];
        FLD_LENGTH: rd_a[g] = len_q[rbuf_i];
        default:    rd_a[g] = base_q[rbuf_i];
      endcase
    end
  end

  assign idx_o   = idx_a[bank_i];
  assign mod_o   = mod_a[bank_i];
  assign len_o   = len_a[bank_i];
  assign base_o  = base_a[bank_i];
  assign rdata_o = rd_a[bank_i];
endmodule

// File: rtl/circ_wrap.sv
module circ_wrap #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] idx_i,
  input  logic [AW-1:0] step_i,
  input  logic [AW-1:0] len_i,
  input  logic [AW-1:0] base_i,
  input  logic          pre_i,
  output logic [AW-1:0] addr_o,
  output logic [AW-1:0] next_o
);
  localparam int XW = AW + 2;

  logic signed [XW-1:0] sum, lo, hi, lenx, fold;

  always_comb begin
    sum  = $signed({2'b00, idx_i}) + $signed({{2{step_i[AW-1]}}, step_i});
    lo   = $signed({2'b00, base_i});
    lenx = $signed({2'b00, len_i});
    hi   = lo + lenx;
    if (len_i == '0)   fold = sum;
    else if (sum >= hi) fold = sum - lenx;
    else if (sum < lo)  fold = sum + lenx;
    else                fold = sum;
  end

  assign addr_o = pre_i ? sum[AW-1:0] : idx_i;
  assign next_o = fold[AW-1:0];
endmodule

// File: rtl/circ_agen.sv
module circ_agen
  import circ_agen_pkg::*;
#(
  parameter int AW   = 32,
  parameter int NBUF = 16,
  localparam int BW  = $clog2(NBUF)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          bank_we_i,
  input  logic          bank_sel_i,
  input  logic          reg_we_i,
  input  logic [BW-1:0] reg_buf_i,
  input  logic [1:0]    reg_fld_i,
  input  logic [AW-1:0] reg_wdata_i,
  output logic [AW-1:0] reg_rdata_o,
  input  logic          acc_valid_i,
  input  logic [BW-1:0] acc_buf_i,
  input  logic          acc_pre_i,
  input  logic          acc_simd_i,
  input  logic          acc_imm_i,
  input  logic [AW-1:0] acc_step_i,
  output logic          out_valid_o,
  output logic [AW-1:0] out_addr_o,
  output logic [AW-1:0] out_addr2_o,
  output logic          out_pair_o
);
  logic          bank_q;
  logic [AW-1:0] a_idx, a_mod, a_len, a_base;
  logic [AW-1:0] step_sel, issue_addr, next_idx;
  logic          upd_en;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        bank_q <= 1'b0;
    else if (bank_we_i) bank_q <= bank_sel_i;
  end

  assign upd_en   = acc_valid_i & ~acc_pre_i;
  assign step_sel = acc_imm_i ? acc_step_i : a_mod;

  circ_regbank #(.AW(AW), .NBUF(NBUF)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .bank_i  (bank_q),
    .we_i    (reg_we_i),
    .wbuf_i  (reg_buf_i),
    .wfld_i  (fld_e'(reg_fld_i)),
    .wdata_i (reg_wdata_i),
    .upd_i   (upd_en),
    .ubuf_i  (acc_buf_i),
    .udata_i (next_idx),
    .abuf_i  (acc_buf_i),
    .idx_o   (a_idx),
    .mod_o   (a_mod),
    .len_o   (a_len),
    .base_o  (a_base),
    .rbuf_i  (reg_buf_i),
    .rfld_i  (fld_e'(reg_fld_i)),
    .rdata_o (reg_rdata_o)
  );

  circ_wrap #(.AW(AW)) u_wrap (
    .idx_i  (a_idx),
    .step_i (step_sel),
    .len_i  (a_len),
    .base_i (a_base),
    .pre_i  (acc_pre_i),
    .addr_o (issue_addr),
    .next_o (next_idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_pair_o  <= 1'b0;
      out_addr_o  <= '0;
      out_addr2_o <= '0;
    end else begin
      out_valid_o <= acc_valid_i;
      out_pair_o  <= acc_valid_i & acc_simd_i;
      if (acc_valid_i) begin
        out_addr_o  <= issue_addr;
        out_addr2_o <= issue_addr + AW'(1);
      end
    end
  end
endmodule

// File: rtl/circ_agen_chk.sv
module circ_agen_chk #(
  parameter int AW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          acc_valid_i,
  input logic          acc_pre_i,
  input logic          acc_simd_i,
  input logic          bank_we_i,
  input logic          bank_sel_i,
  input logic          bank_q,
  input logic          upd_en,
  input logic [AW-1:0] next_idx,
  input logic [AW-1:0] a_idx,
  input logic [AW-1:0] a_len,
  input logic [AW-1:0] a_base,
  input logic [AW-1:0] step_sel,
  input logic          out_valid_o,
  input logic [AW-1:0] out_addr_o,
  input logic [AW-1:0] out_addr2_o,
  input logic          out_pair_o
);
  logic [AW:0]   top_x;
  logic [AW-1:0] mag;
  logic          pre_ok, post_in;

  assign top_x   = {1'b0, a_base} + {1'b0, a_len};
  assign mag     = step_sel[AW-1] ? (~step_sel + AW'(1)) : step_sel;
  assign pre_ok  = (a_len != '0) && (mag <= a_len) &&
                   ({1'b0, a_idx} >= {1'b0, a_base}) && ({1'b0, a_idx} < top_x);
  assign post_in = ({1'b0, next_idx} >= {1'b0, a_base}) && ({1'b0, next_idx} < top_x);

  assert_result_follows_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i |=> out_valid_o);
  assert_no_spurious_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_valid_i |=> !out_valid_o);
  assert_post_issues_old_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && !acc_pre_i) |=> out_addr_o == $past(a_idx));
  assert_pre_no_update_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && acc_pre_i) |-> !upd_en);
  assert_stays_in_buffer_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_en && pre_ok) |-> post_in);
  assert_pair_adjacent_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_pair_o |-> (out_valid_o && out_addr2_o == out_addr_o + AW'(1)));
  assert_pair_only_simd_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && !acc_simd_i) |=> !out_pair_o);
  assert_bank_load_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bank_we_i |=> bank_q == $past(bank_sel_i));
  assert_bank_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bank_we_i |=> $stable(bank_q));
endmodule

bind circ_agen circ_agen_chk #(.AW(AW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .acc_valid_i (acc_valid_i),
  .acc_pre_i   (acc_pre_i),
  .acc_simd_i  (acc_simd_i),
  .bank_we_i   (bank_we_i),
  .bank_sel_i  (bank_sel_i),
  .bank_q      (bank_q),
  .upd_en      (upd_en),
  .next_idx    (next_idx),
  .a_idx       (a_idx),
  .a_len       (a_len),
  .a_base      (a_base),
  .step_sel    (step_sel),
  .out_valid_o (out_valid_o),
  .out_addr_o  (out_addr_o),
  .out_addr2_o (out_addr2_o),
  .out_pair_o  (out_pair_o)
);

// File: tb/circ_agen_bench.sv
`timescale 1ns/1ps
module circ_agen_bench;
  localparam int AW   = 32;
  localparam int NBUF = 16;
  localparam int BW   = $clog2(NBUF);

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          bank_we_i = 1'b0, bank_sel_i = 1'b0;
  logic          reg_we_i = 1'b0;
  logic [BW-1:0] reg_buf_i = '0;
  logic [1:0]    reg_fld_i = '0;
  logic [AW-1:0] reg_wdata_i = '0;
  logic [AW-1:0] reg_rdata_o;
  logic          acc_valid_i = 1'b0, acc_pre_i = 1'b0, acc_simd_i = 1'b0, acc_imm_i = 1'b0;
  logic [BW-1:0] acc_buf_i = '0;
  logic [AW-1:0] acc_step_i = '0;
  logic          out_valid_o, out_pair_o;
  logic [AW-1:0] out_addr_o, out_addr2_o;

  always #5 clk_i = ~clk_i;

  circ_agen #(.AW(AW), .NBUF(NBUF)) u_circ_agen (.*);

  // reference model
  logic [AW-1:0] m_idx  [2][NBUF];
  logic [AW-1:0] m_mod  [2][NBUF];
  logic [AW-1:0] m_len  [2][NBUF];
  logic [AW-1:0] m_base [2][NBUF];
  logic          m_bank;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic check(string tag, logic [AW-1:0] got, logic [AW-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [AW-1:0] m_read(int b, int n, int f);
    case (f)
      0: return m_idx[b][n];
      1: return m_mod[b][n];
      2: return m_len[b][n];
      default: return m_base[b][n];
    endcase
  endfunction

  task automatic tick(string tag);
    logic [AW-1:0] e_a, step, idx, len, base, nxt;
    logic e_v, e_p;
    longint s;
    int b, n;
    b = int'(m_bank); n = int'(acc_buf_i);
    e_v = acc_valid_i; e_p = acc_valid_i & acc_simd_i; e_a = '0;
    if (acc_valid_i) begin
      idx = m_idx[b][n]; len = m_len[b][n]; base = m_base[b][n];
      step = acc_imm_i ? acc_step_i : m_mod[b][n];
      s = longint'(idx) + longint'($signed(step));
      if (acc_pre_i) e_a = AW'(s);
      else begin
        e_a = idx;
        if (len != 0) begin
          if (s >= longint'(base) + longint'(len)) s = s - longint'(len);
          else if (s < longint'(base)) s = s + longint'(len);
        end
        nxt = AW'(s);
        m_idx[b][n] = nxt;
      end
    end
    if (reg_we_i) begin
      case (int'(reg_fld_i))
        0: m_idx[b][reg_buf_i] = reg_wdata_i;
        1: m_mod[b][reg_buf_i] = reg_wdata_i;
        2: m_len[b][reg_buf_i] = reg_wdata_i;
        default: begin
          m_base[b][reg_buf_i] = reg_wdata_i;
          m_idx[b][reg_buf_i]  = reg_wdata_i;
        end
      endcase
    end
    if (bank_we_i) m_bank = bank_sel_i;
    @(posedge clk_i);
    @(negedge clk_i);
    acc_valid_i = 1'b0; reg_we_i = 1'b0; bank_we_i = 1'b0;
    check({tag, " R11 valid"}, AW'(out_valid_o), AW'(e_v));
    check({tag, " R9 pair"}, AW'(out_pair_o), AW'(e_p));
    if (e_v) begin
      check({tag, " addr"}, out_addr_o, e_a);
      check({tag, " R9 addr2"}, out_addr2_o, e_a + AW'(1));
    end
    check({tag, " R2 rdata"}, reg_rdata_o,
          m_read(int'(m_bank), int'(reg_buf_i), int'(reg_fld_i)));
  endtask

  task automatic wreg(int n, int f, logic [AW-1:0] d, string tag);
    reg_we_i = 1'b1; reg_buf_i = BW'(n); reg_fld_i = 2'(f); reg_wdata_i = d;
    tick(tag);
  endtask

  task automatic rreg(int n, int f, logic [AW-1:0] exp, string tag);
    reg_buf_i = BW'(n); reg_fld_i = 2'(f);
    #1 check(tag, reg_rdata_o, exp);
  endtask

  task automatic acc(int n, bit pre, bit simd, bit imm, logic [AW-1:0] st, string tag);
    acc_valid_i = 1'b1; acc_buf_i = BW'(n); acc_pre_i = pre;
    acc_simd_i = simd; acc_imm_i = imm; acc_step_i = st;
    tick(tag);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    for (int b = 0; b < 2; b++)
      for (int n = 0; n < NBUF; n++) begin
        m_idx[b][n] = '0; m_mod[b][n] = '0; m_len[b][n] = '0; m_base[b][n] = '0;
      end
    m_bank = 1'b0;
    repeat (3) @(negedge clk_i);
    check("R1 valid in reset", AW'(out_valid_o), '0);
    rreg(2, 3, '0, "R1 base in reset");
    rst_ni = 1'b1;
    @(negedge clk_i);
    rreg(7, 0, '0, "R1 index after reset");

    // R2 R3: buffer 2 = [100,110), modifier 3
    wreg(2, 2, 32'd10, "R2 length");
    wreg(2, 1, 32'd3, "R2 modifier");
    wreg(2, 3, 32'd100, "R3 base");
    rreg(2, 0, 32'd100, "R3 base loads index");

    // R4 R8: post-modify with register modifier, wraps upward
    for (int k = 0; k < 5; k++) acc(2, 0, 0, 0, '0, "R4 R8 post wrap up");
    rreg(2, 0, 32'd105, "R4 index after wrap");

    // R5: negative immediate, wraps downward
    wreg(2, 0, 32'd101, "R2 index");
    acc(2, 0, 0, 1, -32'sd4, "R5 post wrap down");
    rreg(2, 0, 32'd107, "R5 index after wrap");
    acc(2, 0, 0, 1, -32'sd10, "R5 full length step");

    // R6: length zero is linear, even across the address top
    wreg(5, 3, 32'hFFFF_FFF0, "R2 base");
    acc(5, 0, 0, 1, 32'h20, "R6 linear");
    rreg(5, 0, 32'h0000_0010, "R6 linear index");

    // R7: pre-modify, no wrap, no update
    acc(2, 1, 0, 1, 32'd20, "R7 pre-modify");
    rreg(2, 0, 32'd107, "R7 index unchanged");

    // R9: SIMD pair, post and pre
    acc(2, 0, 1, 0, '0, "R9 simd post");
    acc(2, 1, 1, 1, 32'd2, "R9 simd pre");

    // R10: switch to bank 1, independent contents
    bank_we_i = 1'b1; bank_sel_i = 1'b1;
    tick("R10 select bank 1");
    rreg(2, 3, '0, "R10 bank 1 empty");
    wreg(2, 2, 32'd4, "R10 bank1 length");
    wreg(2, 3, 32'd500, "R10 bank1 base");
    acc(2, 0, 0, 1, 32'd3, "R10 bank1 access");
    acc(2, 0, 0, 1, 32'd3, "R10 bank1 wrap");
    bank_we_i = 1'b1; bank_sel_i = 1'b0;
    tick("R10 select bank 0");
    rreg(2, 3, 32'd100, "R10 bank 0 base kept");
    acc(2, 0, 0, 0, '0, "R10 bank0 access");

    // R12: write and update to the same index in one cycle
    reg_we_i = 1'b1; reg_buf_i = 2; reg_fld_i = 0; reg_wdata_i = 32'd105;
    acc(2, 0, 0, 0, '0, "R12 collision");
    rreg(2, 0, 32'd105, "R12 write wins");
    acc(2, 0, 0, 0, '0, "R12 next issue");

    // idle cycles
    tick("R11 idle");
    tick("R11 idle");

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule